// File: doc/BRIEF.md
# Two-Wire Codec Control Register Slave

This block is a write-only target on a two-wire serial control bus. The data line is open-drain. The block runs on a system clock and oversamples both bus lines through a synchronizer. It finds start and stop conditions in the sampled lines and compares the first byte of each transaction with its own 7-bit device address. A matching write is acknowledged. Every following pair of bytes forms a 16-bit control word. The upper seven bits of the word select a register and the lower nine bits are the value to store.

Ten control registers, at addresses 0 to 9, sit behind the bus and are presented side by side on one flat output vector. Register `n` occupies bits `[9n+8:9n]`. Two extra rules apply to writes:

- A write to a left-channel register (address 0 or 2) whose bit 8 is set also writes the same value to the paired right-channel register (address 1 or 3).
- A write to address 15 returns every register to its power-on value.

Top module: `codec_ctl_slave`

## Requirements
- R1: After reset, `sda_pull_o` is 0 and registers 0..9 hold 0x097, 0x097, 0x079, 0x079, 0x00A, 0x008, 0x007, 0x001, 0x020, 0x000. In register 0, bit 8 is the link flag, bit 7 is mute and bits 4..0 are the volume code.
- R2: An address byte equal to `{DEV_ADDR, 0}`, sent MSB first with bit 0 = 0 meaning write, is acknowledged. The block drives `sda_pull_o` high during the ninth SCL pulse.
- R3: An address byte that does not match, or that has bit 0 = 1 (read), is not acknowledged. The data bytes that follow it in the same transaction are also not acknowledged and change no register.
- R4: The two bytes after the address byte form a word, first byte as bits 15..8. Bits 15..9 select the register and bits 8..0 are its new value. The register changes only once the second byte has been acknowledged.
- R5: Each data byte of a selected transaction is acknowledged on its ninth SCL pulse.
- R6: A write to address 0 or 2 with data bit 8 set also stores the same data in address 1 or 3 respectively.
- R7: A write to address 0 or 2 with data bit 8 clear leaves the paired right-channel register unchanged.
- R8: A write to address 15 restores every register to its R1 value, whatever the data.
- R9: A write to an address in 10..14 or 16..127 is acknowledged and leaves all registers unchanged.
- R10: A stop or repeated start after only the first data byte of a word discards that byte, and no register changes.
- R11: Further byte pairs inside one transaction are each taken as another complete word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_pull_o | output | 1 | 1 = drive the data line low (acknowledge), 0 = release |
| reg_bank_o | output | NUM_REGS*DATA_W (90) | Register n on bits [9n+8:9n] |

## Verification
The bench builds the block with a device address of 0x35 instead of the default. This shows that the address compare follows the parameter, and it makes the default address 0x1A a valid non-matching pattern. All other parameters keep their defaults: two synchronizer stages, ten registers, 9-bit data and 7-bit register addresses. With these values the bench can reach the link pairs, the reset address 15, the unlisted addresses just above the register range and high unlisted addresses. Each bus phase is held for six system clocks, which is longer than the sync-and-detect latency. Acknowledges can therefore be sampled in the middle of the ninth SCL-high phase.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_HI,
    ST_LO,
    ST_IGNORE
  } bus_st_e;

  // Power-on value of each control register
  function automatic logic [8:0] reg_default(input int idx);
    case (idx)
      0, 1:    return 9'h097;
      2, 3:    return 9'h079;
      4:       return 9'h00A;
      5:       return 9'h008;
      6:       return 9'h007;
      7:       return 9'h001;
      8:       return 9'h020;
      default: return 9'h000;
    endcase
  endfunction

  // Right-channel registers that follow their left partner at idx-1
  function automatic bit is_right_partner(input int idx);
    return (idx == 1) || (idx == 3);
  endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '1;
    end else begin
      pipe[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/tw_bus_fsm.sv
module tw_bus_fsm
  import codec_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1A,
  parameter int         WORD_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  output logic              sda_pull_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o,
  output bus_st_e           st_o,
  output logic              stop_o
);

  localparam int BYTE_W = WORD_W / 2;
  localparam int CNT_W  = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] ACK_CNT  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(BYTE_W + 1);

  logic              scl_q, sda_q;
  logic [BYTE_W-1:0] shreg, hi_q;
  logic [CNT_W-1:0]  bitcnt;
  bus_st_e           st;

  wire start_w = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_w  = scl_s & scl_q & ~sda_q & sda_s;
  wire rise_w  = scl_s & ~scl_q;
  wire fall_w  = ~scl_s & scl_q;
  wire active  = (st == ST_ADDR) || (st == ST_HI) || (st == ST_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      scl_q        <= 1'b1;
      sda_q        <= 1'b1;
      bitcnt       <= '0;
      shreg        <= '0;
      hi_q         <= '0;
      sda_pull_o   <= 1'b0;
      word_valid_o <= 1'b0;
      word_o       <= '0;
    end else begin
      scl_q        <= scl_s;
      sda_q        <= sda_s;
      word_valid_o <= 1'b0;
      if (start_w) begin
        st         <= ST_ADDR;
        bitcnt     <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_w) begin
        st         <= ST_IDLE;
        bitcnt     <= '0;
        sda_pull_o <= 1'b0;
      end else if (active) begin
        if (rise_w && bitcnt < ACK_CNT) begin
          shreg  <= {shreg[BYTE_W-2:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
        end else if (fall_w && bitcnt == ACK_CNT) begin
          bitcnt <= DONE_CNT;
          case (st)
            ST_ADDR: begin
              if (shreg == {DEV_ADDR, 1'b0}) sda_pull_o <= 1'b1;
              else                           st         <= ST_IGNORE;
            end
            ST_HI: begin
              sda_pull_o <= 1'b1;
              hi_q       <= shreg;
            end
            default: sda_pull_o <= 1'b1;
          endcase
        end else if (fall_w && bitcnt == DONE_CNT) begin
          sda_pull_o <= 1'b0;
          bitcnt     <= '0;
          case (st)
            ST_ADDR: st <= ST_HI;
            ST_HI:   st <= ST_LO;
            default: begin
              st           <= ST_HI;
              word_valid_o <= 1'b1;
              word_o       <= {hi_q, shreg};
            end
          endcase
        end
      end
    end
  end

  assign st_o   = st;
  assign stop_o = stop_w;

endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import codec_ctl_pkg::*;
#(
  parameter int NUM_REGS   = 10,
  parameter int DATA_W     = 9,
  parameter int RADDR_W    = 7,
  parameter int RESET_ADDR = 15
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [RADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_REGS*DATA_W-1:0] bank_o
);

  logic [DATA_W-1:0] regs [NUM_REGS];
  wire wipe = wr_en && (wr_addr == RADDR_W'(RESET_ADDR));

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= DATA_W'(reg_default(i));
    end else if (wr_en) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wr_addr == RADDR_W'(i) ||
            (is_right_partner(i) && wr_addr == RADDR_W'(i - 1) && wr_data[DATA_W-1]))
          regs[i] <= wr_data;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign bank_o[g*DATA_W +: DATA_W] = regs[g];
  end

endmodule

// File: rtl/codec_ctl_slave.sv
module codec_ctl_slave
  import codec_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h1A,
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_REGS    = 10,
  parameter int         DATA_W      = 9,
  parameter int         RADDR_W     = 7,
  parameter int         RESET_ADDR  = 15
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_pull_o,
  output logic [NUM_REGS*DATA_W-1:0] reg_bank_o
);

  localparam int WORD_W = RADDR_W + DATA_W;

  logic              scl_s, sda_s;
  logic              word_valid, stop_seen;
  logic [WORD_W-1:0] word;
  bus_st_e           bus_st;

  tw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i ({scl_i, sda_i}),
    .q_o ({scl_s, sda_s})
  );

  tw_bus_fsm #(.DEV_ADDR(DEV_ADDR), .WORD_W(WORD_W)) fsm_i (
    .clk          (clk),
    .rst          (rst),
    .scl_s        (scl_s),
    .sda_s        (sda_s),
    .sda_pull_o   (sda_pull_o),
    .word_valid_o (word_valid),
    .word_o       (word),
    .st_o         (bus_st),
    .stop_o       (stop_seen)
  );

  ctl_regfile #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .RADDR_W(RADDR_W), .RESET_ADDR(RESET_ADDR)
  ) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (word_valid),
    .wr_addr (word[WORD_W-1 -: RADDR_W]),
    .wr_data (word[DATA_W-1:0]),
    .bank_o  (reg_bank_o)
  );

endmodule

// File: rtl/codec_ctl_checker.sv
module codec_ctl_checker
  import codec_ctl_pkg::*;
#(
  parameter int NUM_REGS   = 10,
  parameter int DATA_W     = 9,
  parameter int RADDR_W    = 7,
  parameter int RESET_ADDR = 15
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         sda_pull,
  input bus_st_e                      st,
  input logic                         word_valid,
  input logic [RADDR_W+DATA_W-1:0]    word,
  input logic                         stop_seen,
  input logic [NUM_REGS*DATA_W-1:0]   bank
);

  logic [NUM_REGS*DATA_W-1:0] dflt;
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) dflt[i*DATA_W +: DATA_W] = DATA_W'(reg_default(i));
  end

  wire [RADDR_W-1:0] w_addr = word[RADDR_W+DATA_W-1 -: RADDR_W];
  wire [DATA_W-1:0]  w_data = word[DATA_W-1:0];

  assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bank == dflt && !sda_pull));

  assert_no_pull_unselected_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IGNORE || st == ST_IDLE) |-> !sda_pull);

  assert_update_on_commit_R4: assert property (@(posedge clk) disable iff (rst)
    !word_valid |=> $stable(bank));

  assert_link_copy_R6: assert property (@(posedge clk) disable iff (rst)
    (word_valid && w_addr == RADDR_W'(0) && w_data[DATA_W-1])
      |=> bank[DATA_W +: DATA_W] == bank[0 +: DATA_W]);

  assert_reset_reg_R8: assert property (@(posedge clk) disable iff (rst)
    (word_valid && w_addr == RADDR_W'(RESET_ADDR)) |=> bank == dflt);

  assert_unlisted_R9: assert property (@(posedge clk) disable iff (rst)
    (word_valid && w_addr >= RADDR_W'(NUM_REGS) && w_addr != RADDR_W'(RESET_ADDR))
      |=> $stable(bank));

  assert_release_on_stop_R10: assert property (@(posedge clk) disable iff (rst)
    stop_seen |=> !sda_pull);

endmodule

bind codec_ctl_slave codec_ctl_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .RADDR_W(RADDR_W), .RESET_ADDR(RESET_ADDR)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .sda_pull   (sda_pull_o),
  .st         (bus_st),
  .word_valid (word_valid),
  .word       (word),
  .stop_seen  (stop_seen),
  .bank       (reg_bank_o)
);

// File: tb/codec_ctl_slave_tb_top.sv
module codec_ctl_slave_tb_top;

  localparam logic [6:0] DEV = 7'h35;
  localparam int NR = 10, DW = 9, Q = 6;

  logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  logic [NR*DW-1:0] bank;
  wire sda_line = sda_m & ~sda_pull;

  int vectors = 0, fails = 0;
  bit done = 0;
  logic [8:0] model [NR];

  always #5 clk = ~clk;

  codec_ctl_slave #(.DEV_ADDR(DEV)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .reg_bank_o(bank)
  );

  function automatic logic [8:0] dflt(input int i);
    logic [8:0] t [10] = '{9'h097, 9'h097, 9'h079, 9'h079, 9'h00A,
                           9'h008, 9'h007, 9'h001, 9'h020, 9'h000};
    return t[i];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NR; i++) model[i] = dflt(i);
  endtask

  task automatic model_write(input logic [6:0] a, input logic [8:0] d);
    if (a == 7'd15) model_reset();
    else if (a < 7'(NR)) begin
      model[a] = d;
      if ((a == 7'd0 || a == 7'd2) && d[8]) model[a+1] = d;
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_bank(input string req);
    hold(4);
    for (int i = 0; i < NR; i++) chk(req, 32'(bank[i*DW +: DW]), 32'(model[i]));
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q); scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q); scl_m = 1'b1; hold(Q);
    sda_m = 1'b1; hold(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(Q); scl_m = 1'b1; hold(2*Q); scl_m = 1'b0; hold(Q);
    end
    sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q);
    acked = !sda_line;
    hold(Q); scl_m = 1'b0; hold(Q);
  endtask

  // Full write of one word; checks every acknowledge against expectation
  task automatic write_word(input logic [7:0] abyte, input logic [6:0] ra,
                            input logic [8:0] d, input bit sel, input string req);
    bit a;
    bus_start();
    send_byte(abyte, a);            chk({req, "/R2/R3 addr ack"}, 32'(a), 32'(sel));
    send_byte({ra, d[8]}, a);       chk({req, "/R5 hi ack"}, 32'(a), 32'(sel));
    send_byte(d[7:0], a);           chk({req, "/R5 lo ack"}, 32'(a), 32'(sel));
    bus_stop();
    if (sel) model_write(ra, d);
    chk_bank(req);
  endtask

  initial begin
    bit a;
    int unsigned r;
    r = $urandom(32'd4242);
    model_reset();
    hold(5);
    rst = 1'b0;
    hold(2);
    chk("R1 pull", 32'(sda_pull), 32'd0);
    chk_bank("R1");

    write_word({DEV, 1'b0}, 7'd0, 9'h015, 1, "R4");
    write_word({DEV, 1'b0}, 7'd0, 9'h033, 1, "R7");
    write_word({DEV, 1'b0}, 7'd0, 9'h1C4, 1, "R6");
    write_word({DEV, 1'b0}, 7'd2, 9'h16A, 1, "R6");
    write_word({DEV, 1'b0}, 7'd2, 9'h055, 1, "R7");
    write_word({DEV, 1'b0}, 7'd9, 9'h1FF, 1, "R4");
    write_word({DEV, 1'b0}, 7'd12, 9'h0AA, 1, "R9");
    write_word({DEV, 1'b0}, 7'd100, 9'h123, 1, "R9");
    write_word({7'h1A, 1'b0}, 7'd4, 9'h0F0, 0, "R3");
    write_word({DEV, 1'b1}, 7'd5, 9'h0F0, 0, "R3");

    // R10: stop after first data byte
    bus_start();
    send_byte({DEV, 1'b0}, a); chk("R10 addr ack", 32'(a), 32'd1);
    send_byte({7'd6, 1'b0}, a);
    bus_stop();
    chk_bank("R10 stop");
    // R10: repeated start after first data byte, then a full word
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte({7'd7, 1'b1}, a);
    bus_start();
    send_byte({DEV, 1'b0}, a); chk("R10 restart ack", 32'(a), 32'd1);
    send_byte({7'd5, 1'b0}, a);
    send_byte(8'h3C, a);
    bus_stop();
    model_write(7'd5, 9'h03C);
    chk_bank("R10 restart");

    // R11: three words in one transaction
    bus_start();
    send_byte({DEV, 1'b0}, a);
    for (int k = 0; k < 3; k++) begin
      send_byte({7'(4 + k), 1'b1}, a); chk("R11 hi ack", 32'(a), 32'd1);
      send_byte(8'(8'h11 * (k + 1)), a); chk("R11 lo ack", 32'(a), 32'd1);
      model_write(7'(4 + k), {1'b1, 8'(8'h11 * (k + 1))});
    end
    bus_stop();
    chk_bank("R11");

    write_word({DEV, 1'b0}, 7'd15, 9'h000, 1, "R8");

    for (int n = 0; n < 40; n++) begin
      logic [6:0] ra;
      logic [8:0] d;
      int sel;
      r   = $urandom();
      d   = 9'($urandom());
      sel = int'(r[1:0]);
      if (sel == 0)      ra = 7'(r[9:8]);
      else if (sel == 1) ra = 7'(r[12:8] % 16);
      else               ra = 7'(r[14:8]);
      if (r[20:18] == 3'd0)
        write_word({DEV ^ 7'h04, 1'b0}, ra, d, 0, "R3 rand");
      else
        write_word({DEV, 1'b0}, ra, d, 1, "R4 rand");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule